// File: doc/BRIEF.md
# Next program counter unit

This block owns the 32-bit program counter of a simple load/store processor and decides, once per clock, where the next instruction is fetched from. It looks at the instruction word currently being executed, at an equality flag computed by the datapath for the two registers that instruction names, and at a register value used for register-indirect jumps. From these it chooses one of four successor addresses: the next sequential word, a PC-relative branch target, a region-relative absolute jump target, or a full register target.

Branch targets are formed from the address of the following instruction plus a signed, word-scaled 16-bit offset. Absolute jumps keep the top four bits of the following instruction's address and replace the rest with a 26-bit word index. The return address for call-style jumps is offered on a separate output so that the register-file write path can store it. A synchronous reset puts the counter at a boot address.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes the boot address (default 0x0000_0000) on that edge.
- R2: An instruction whose opcode (bits 31:26) is not 2, 3, 4 or 5, and which is not opcode 0 with funct (bits 5:0) equal to 8, makes the next `pc_q` equal to `pc_q + 4`.
- R3: Opcode 4 (branch-if-equal) with `regs_equal` high makes the next `pc_q` equal to `pc_q + 4 + (sign-extended bits 15:0 shifted left by two)`; negative offsets branch backwards.
- R4: A branch that is not taken (opcode 4 with `regs_equal` low, or opcode 5 with `regs_equal` high) makes the next `pc_q` equal to `pc_q + 4`.
- R5: Opcode 5 (branch-if-not-equal) with `regs_equal` low takes the branch with the same target formula as R3.
- R6: Opcode 2 (jump) makes the next `pc_q` equal to `{(pc_q+4)[31:28], instr[25:0], 2'b00}`; the region bits come from `pc_q+4`, not from `pc_q`.
- R7: Opcode 3 (jump-and-link) uses the same target as R6.
- R8: Opcode 0 with funct 8 (register jump) makes the next `pc_q` equal to `jr_value` with its two low bits cleared.
- R9: `link_addr` always equals `pc_q + 4` in the same cycle.
- R10: `pc_q` bits 1:0 are zero in every cycle after reset.
- R11: All address arithmetic is modulo 2^32: sequential fetch from 0xFFFF_FFFC yields 0x0000_0000, and branch targets wrap the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word being executed at `pc_q` |
| regs_equal | input | 1 | High when the two compared registers hold equal values |
| jr_value | input | 32 | Register contents used as the register-jump target |
| pc_q | output | 32 | Current program counter |
| link_addr | output | 32 | Return address (`pc_q + 4`) for call-style jumps |

## Verification
The awkward cases all depend on where the counter currently sits: wrapping past the top of the address space, and an absolute jump issued from the last word of a 256 MB region, where the region bits of `pc_q` and `pc_q + 4` differ. The counter cannot be loaded directly, so the stimulus first issues a register jump to a chosen address such as 0xFFFF_FFF8 or 0xEFFF_FFFC, and then applies sequential, branch or jump words from that point. Random instruction words with weighted opcodes and random equality flags then cover taken and untaken branches with offsets of both signs.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int XLEN      = 32;
    localparam int OPC_W     = 6;
    localparam int FUNCT_W   = 6;
    localparam int IMM_W     = 16;
    localparam int TGT_W     = 26;
    localparam int REGION_W  = XLEN - TGT_W - 2;
    localparam int BYTE_STEP = 4;

    localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_JLINK   = 6'd3;
    localparam logic [OPC_W-1:0]   OPC_BEQ     = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_BNE     = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_JREG     = 6'd8;

    typedef logic [XLEN-1:0] addr_t;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_REG    = 2'd3
    } next_src_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [TGT_W-1:0]   target;
        logic [IMM_W-1:0]   imm;
        logic [FUNCT_W-1:0] funct;
    } instr_fields_t;

    typedef struct packed {
        addr_t seq;
        addr_t branch;
        addr_t jump;
        addr_t regj;
    } targets_t;

    function automatic instr_fields_t split_instr(input logic [XLEN-1:0] w);
        instr_fields_t f;
        f.opcode = w[XLEN-1 -: OPC_W];
        f.target = w[TGT_W-1:0];
        f.imm    = w[IMM_W-1:0];
        f.funct  = w[FUNCT_W-1:0];
        return f;
    endfunction

    function automatic addr_t word_offset(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    endfunction

    function automatic addr_t word_align(input addr_t a);
        return a & ~addr_t'(BYTE_STEP - 1);
    endfunction

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    input  logic               regs_equal,
    output next_src_e          sel
);
    always_comb begin
        sel = SRC_SEQ;
        unique case (opcode)
            OPC_JUMP, OPC_JLINK: sel = SRC_JUMP;
            OPC_BEQ:     sel = regs_equal  ? SRC_BRANCH : SRC_SEQ;
            OPC_BNE:     sel = !regs_equal ? SRC_BRANCH : SRC_SEQ;
            OPC_SPECIAL: sel = (funct == FN_JREG) ? SRC_REG : SRC_SEQ;
            default:     sel = SRC_SEQ;
        endcase
    end
endmodule

// File: rtl/pcseq_targets.sv
module pcseq_targets
    import pcseq_pkg::*;
(
    input  addr_t            pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [TGT_W-1:0] target,
    input  addr_t            jr_value,
    output targets_t         tg
);
    addr_t pc_inc;

    always_comb begin
        pc_inc    = pc + addr_t'(BYTE_STEP);
        tg.seq    = pc_inc;
        tg.branch = pc_inc + word_offset(imm);
        tg.jump   = {pc_inc[XLEN-1 -: REGION_W], target, 2'b00};
        tg.regj   = word_align(jr_value);
    end
endmodule

// File: rtl/pcseq_mux.sv
module pcseq_mux
    import pcseq_pkg::*;
(
    input  next_src_e sel,
    input  targets_t  tg,
    output addr_t     next_pc
);
    always_comb begin
        unique case (sel)
            SRC_BRANCH: next_pc = tg.branch;
            SRC_JUMP:   next_pc = tg.jump;
            SRC_REG:    next_pc = tg.regj;
            default:    next_pc = tg.seq;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter logic [31:0] BOOT_ADDR = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic        regs_equal,
    input  logic [31:0] jr_value,
    output logic [31:0] pc_q,
    output logic [31:0] link_addr
);
    localparam addr_t BOOT_ALIGNED = word_align(BOOT_ADDR);

    instr_fields_t fields;
    next_src_e     sel;
    targets_t      tg;
    addr_t         pc_r;
    addr_t         pc_next;

    assign fields = split_instr(instr);

    pcseq_decode u_decode (
        .opcode     (fields.opcode),
        .funct      (fields.funct),
        .regs_equal (regs_equal),
        .sel        (sel)
    );

    pcseq_targets u_targets (
        .pc       (pc_r),
        .imm      (fields.imm),
        .target   (fields.target),
        .jr_value (jr_value),
        .tg       (tg)
    );

    pcseq_mux u_mux (
        .sel     (sel),
        .tg      (tg),
        .next_pc (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_r <= BOOT_ALIGNED;
        else     pc_r <= pc_next;
    end

    assign pc_q      = pc_r;
    assign link_addr = tg.seq;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic        regs_equal,
    input logic [31:0] jr_value,
    input logic [31:0] pc_q,
    input logic [31:0] link_addr
);
    logic [5:0] opc;
    logic       is_jreg;
    logic       is_other;

    assign opc      = instr[31:26];
    assign is_jreg  = (opc == 6'd0) && (instr[5:0] == 6'd8);
    assign is_other = !is_jreg && (opc != 6'd2) && (opc != 6'd3)
                      && (opc != 6'd4) && (opc != 6'd5);

    assert_boot_R1: assert property (@(posedge clk)
        rst |=> (pc_q == 32'h0000_0000));

    assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
        is_other |=> (pc_q == $past(pc_q) + 32'd4));

    assert_beq_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && regs_equal) |=>
        (pc_q == $past(pc_q) + 32'd4 +
                 {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    assert_untaken_R4: assert property (@(posedge clk) disable iff (rst)
        ((opc == 6'd4 && !regs_equal) || (opc == 6'd5 && regs_equal)) |=>
        (pc_q == $past(pc_q) + 32'd4));

    assert_bne_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd5 && !regs_equal) |=>
        (pc_q == $past(pc_q) + 32'd4 +
                 {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    assert_jump_R6_R7: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd2 || opc == 6'd3) |=>
        (pc_q == {$past(link_addr[31:28]), $past(instr[25:0]), 2'b00}));

    assert_regjump_R8: assert property (@(posedge clk) disable iff (rst)
        is_jreg |=> (pc_q == {$past(jr_value[31:2]), 2'b00}));

    assert_link_R9: assert property (@(posedge clk) disable iff (rst)
        link_addr == pc_q + 32'd4);

    assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);

endmodule

bind pc_sequencer pc_sequencer_chk u_chk (.*);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic        regs_equal = 1'b0;
    logic [31:0] jr_value = 32'h0;
    logic [31:0] pc_q;
    logic [31:0] link_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc;

    always #2.5 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .regs_equal (regs_equal),
        .jr_value   (jr_value),
        .pc_q       (pc_q),
        .link_addr  (link_addr)
    );

    function automatic logic [31:0] ref_next(input logic [31:0] pc,
                                             input logic [31:0] w,
                                             input logic eq,
                                             input logic [31:0] rv);
        logic [31:0] inc;
        logic [31:0] off;
        inc = pc + 32'd4;
        off = {{14{w[15]}}, w[15:0], 2'b00};
        case (w[31:26])
            6'd2, 6'd3: return {inc[31:28], w[25:0], 2'b00};
            6'd4: return eq  ? inc + off : inc;
            6'd5: return !eq ? inc + off : inc;
            6'd0: return (w[5:0] == 6'd8) ? {rv[31:2], 2'b00} : inc;
            default: return inc;
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] w, input logic eq);
        case (w[31:26])
            6'd2: return "R6";
            6'd3: return "R7";
            6'd4: return eq ? "R3" : "R4";
            6'd5: return eq ? "R4" : "R5";
            6'd0: return (w[5:0] == 6'd8) ? "R8" : "R2";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] w, input logic eq,
                        input logic [31:0] rv, input string req);
        logic [31:0] exp;
        string t;
        t = (req == "") ? tag_of(w, eq) : req;
        instr      = w;
        regs_equal = eq;
        jr_value   = rv;
        exp = ref_next(model_pc, w, eq, rv);
        @(posedge clk);
        @(negedge clk);
        model_pc = exp;
        check(t, pc_q, exp);
        check("R9", link_addr, exp + 32'd4);
        check("R10", {30'd0, pc_q[1:0]}, 32'd0);
    endtask

    function automatic logic [31:0] rand_instr();
        logic [31:0] w;
        w = $urandom();
        case ($urandom_range(0, 7))
            0: w[31:26] = 6'd4;
            1: w[31:26] = 6'd5;
            2: w[31:26] = 6'd2;
            3: w[31:26] = 6'd3;
            4: begin w[31:26] = 6'd0; w[5:0] = 6'd8; end
            5: begin w[31:26] = 6'd0; if (w[5:0] == 6'd8) w[5:0] = 6'd32; end
            default: ;
        endcase
        return w;
    endfunction

    localparam logic [31:0] NOP = 32'h0000_0020;

    initial begin
        void'($urandom(32'd1234));
        model_pc = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", pc_q, 32'h0);
        check("R9", link_addr, 32'h4);
        rst = 1'b0;

        step(NOP, 1'b0, 32'h0, "R2");
        step(32'h0000_0009, 1'b1, 32'h1234_5670, "R2");
        step(32'h1000_FFFF, 1'b1, 32'h0, "R3");
        step(32'h1000_FFFF, 1'b0, 32'h0, "R4");
        step(32'h1400_0003, 1'b0, 32'h0, "R5");
        step(32'h1400_0003, 1'b1, 32'h0, "R4");
        // register jump with unaligned value
        step(32'h0000_0008, 1'b0, 32'h8765_4323, "R8");
        // walk off the top of the address space
        step(32'h0000_0008, 1'b0, 32'hFFFF_FFF8, "R8");
        step(NOP, 1'b0, 32'h0, "R11");
        step(NOP, 1'b0, 32'h0, "R11");
        // backward branch below zero wraps
        step(32'h1000_8000, 1'b1, 32'h0, "R11");
        // jump from the last word of a region takes the next region
        step(32'h0000_0008, 1'b0, 32'hEFFF_FFFC, "R8");
        step(32'h0800_0001, 1'b0, 32'h0, "R6");
        step(32'h0C3F_FFFF, 1'b1, 32'h0, "R7");

        for (int i = 0; i < 600; i++)
            step(rand_instr(), 1'($urandom_range(0, 1)), $urandom(), "");

        // reset in mid-run
        instr = 32'h0800_1234;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", pc_q, 32'h0);
        rst = 1'b0;
        model_pc = 32'h0;
        step(NOP, 1'b0, 32'h0, "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule